// File: doc/BRIEF.md
# Tick-Gated Constant-Frequency PWM Stage

This block produces a pulse-width-modulated level from two 8-bit settings, a period value and an on-count. Its counter moves only on single-cycle enable ticks that come from an upstream variable-rate source, such as a numerically controlled oscillator. The system clock does not advance it. One output period is therefore period+1 ticks long, and the duty cycle is on / (period+1).

The period and on-count are copied into shadow registers only when the counter wraps to zero, or while the stage is stopped. A change made in the middle of a period therefore cannot shorten or split the current pulse. If the on-count is larger than the period, the output stays high. If the on-count is zero, the output stays low. Deasserting run clears the counter and forces the output low. When run is asserted again, a fresh period starts using the settings present on that edge.

Top module: `tick_pwm`

## Requirements
- R1: While rst_ni is low and after its release, pwm_o is 0 and the stage is idle.
- R2: While running, the counter advances by one on each cycle with tick_i high. It counts from 0 up to the latched period and wraps to 0 on the next tick, so each output period is period+1 ticks long.
- R3: pwm_o is high exactly while the counter is below the latched on-count. That gives on ticks high per period.
- R4: A latched on-count greater than the latched period (for example on 0xFF, period 0xFE) makes pwm_o constantly high while running.
- R5: A latched on-count of 0 makes pwm_o constantly low.
- R6: In a running cycle with tick_i low, the counter and pwm_o hold their values.
- R7: While running, new period_i and on_i values are latched only on the tick that wraps the counter to 0. At any other time they have no effect on pwm_o.
- R8: In the cycle after run_i is sampled low, pwm_o is 0 and the counter is 0.
- R9: tick_i has no effect while run_i is low. On the first cycle with run_i high, the stage starts a new period at count 0 using the period_i and on_i present on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Stage enable; low clears the counter and output |
| tick_i | input | 1 | One-cycle count enable from the rate source |
| period_i | input | 8 | Period setting; period lasts period_i+1 ticks |
| on_i | input | 8 | On-count setting; number of high ticks per period |
| pwm_o | output | 1 | PWM level |

## Verification
Two events can fall in the same cycle. A tick can wrap the counter while period_i and on_i are changing. A run drop can also arrive together with a tick. The bench provokes both by toggling the settings on random cycles with a random tick density, so that many updates land exactly on a wrapping tick, and by dropping run on cycles where tick is high. A behavioural model that latches only at wrap or while stopped predicts pwm_o. The output is compared with it on every clock, so a value latched one tick early or late, or a tick counted during a stop, shows up as a mismatch.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;
  localparam int unsigned PWM_W = 8;
  typedef enum logic {ST_IDLE = 1'b0, ST_LIVE = 1'b1} run_st_e;
endpackage

// File: rtl/tick_pwm_shadow.sv
module tick_pwm_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] on_i,
  output logic [W-1:0] per_o,
  output logic [W-1:0] on_o
);
  logic [W-1:0] per_q, on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      on_q  <= '0;
    end else if (load_i) begin
      per_q <= period_i;
      on_q  <= on_i;
    end
  end

  assign per_o = per_q;
  assign on_o  = on_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(per_q) && $stable(on_q)));
endmodule

// File: rtl/tick_pwm_counter.sv
module tick_pwm_counter
  import tick_pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         live_o,
  output logic         load_o
);
  run_st_e      st_q;
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (st_q == ST_LIVE) && run_i && tick_i && (cnt_q == per_i);
  assign load_o = !run_i || (st_q == ST_IDLE) || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (!run_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_IDLE) begin
      st_q  <= ST_LIVE;
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign live_o = (st_q == ST_LIVE);

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LIVE) |-> (cnt_q <= per_i));
  assert_no_tick_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_LIVE) && run_i && !tick_i) |=> $stable(cnt_q));
  assert_stop_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0 && st_q == ST_IDLE));
endmodule

// File: rtl/tick_pwm_cmp.sv
module tick_pwm_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         live_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] on_i,
  output logic         pwm_o
);
  assign pwm_o = live_i && (cnt_i < on_i);
endmodule

// File: rtl/tick_pwm.sv
module tick_pwm #(
  parameter int unsigned W = tick_pwm_pkg::PWM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] on_i,
  output logic         pwm_o
);
  logic [W-1:0] per_s, on_s, cnt;
  logic         live, load;

  tick_pwm_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .run_i, .tick_i,
    .per_i(per_s), .cnt_o(cnt), .live_o(live), .load_o(load)
  );

  tick_pwm_shadow #(.W(W)) u_shd (
    .clk_i, .rst_ni, .load_i(load),
    .period_i, .on_i, .per_o(per_s), .on_o(on_s)
  );

  tick_pwm_cmp #(.W(W)) u_cmp (
    .live_i(live), .cnt_i(cnt), .on_i(on_s), .pwm_o
  );

  assert_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && on_s > per_s) |-> pwm_o);
  assert_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_s == '0) |-> !pwm_o);
  assert_stop_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pwm_o);
  assert_idle_R1: assert property (@(posedge clk_i) !live |-> !pwm_o);
endmodule

// File: tb/tick_pwm_bench.sv
module tick_pwm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0, tick = 1'b0;
  logic [7:0] per = 8'd0, onc = 8'd0;
  logic       pwm;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  // behavioural model
  int m_act, m_cnt, m_per, m_on;

  always #5 clk = ~clk;

  tick_pwm u_tick_pwm (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tick_i(tick),
    .period_i(per), .on_i(onc), .pwm_o(pwm)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_per = 0; m_on = 0;
    end else if (!run) begin
      m_act = 0; m_cnt = 0; m_per = per; m_on = onc;
    end else if (m_act == 0) begin
      m_act = 1; m_cnt = 0; m_per = per; m_on = onc;
    end else if (tick) begin
      if (m_cnt == m_per) begin
        m_cnt = 0; m_per = per; m_on = onc;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp;
      exp = (m_act != 0) && (m_cnt < m_on);
      checks++;
      if (pwm !== exp) begin
        errors++;
        $display("FAIL %s: pwm_o=%b expected %b (cnt %0d per %0d on %0d)",
                 phase, pwm, exp, m_cnt, m_per, m_on);
      end
    end
  end

  task automatic drive(input logic r, input logic t, input int p, input int o);
    @(negedge clk);
    run = r; tick = t; per = 8'(p); onc = 8'(o);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int last, gap;
    repeat (3) @(negedge clk);
    chk("R1", pwm, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pwm, 0);

    // R2/R3: per 4, on 2, tick every cycle -> rising edges 5 cycles apart
    phase = "R2";
    drive(1, 1, 4, 2);
    last = -1; gap = 0;
    for (int i = 0; i < 30; i++) begin
      logic prev;
      prev = pwm;
      @(negedge clk);
      if (!prev && pwm) begin
        if (last >= 0) gap = i - last;
        last = i;
      end
    end
    chk("R2", gap, 5);
    phase = "R3";
    begin
      int hi = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); hi += pwm; end
      chk("R3", hi, 20);
    end

    // R4: on above period -> flat high
    phase = "R4";
    drive(0, 0, 254, 255);
    drive(1, 1, 254, 255);
    begin
      int hi = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); hi += pwm; end
      chk("R4", hi, 300);
    end

    // R5: on zero -> flat low
    phase = "R5";
    drive(0, 0, 3, 0);
    drive(1, 1, 3, 0);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); hi += pwm; end
      chk("R5", hi, 0);
    end

    // R6: no ticks -> hold
    phase = "R6";
    drive(0, 0, 6, 3);
    drive(1, 1, 6, 3);
    drive(1, 1, 6, 3);
    drive(1, 0, 6, 3);
    begin
      logic held;
      held = pwm;
      for (int i = 0; i < 20; i++) begin @(negedge clk); chk("R6", pwm, held); end
    end

    // R7: settings toggle on random cycles, random tick density
    phase = "R7";
    for (int i = 0; i < 4000; i++)
      drive(1, ($urandom_range(0, 2) != 0), $urandom_range(0, 5), $urandom_range(0, 7));

    // R8: drop run together with ticks
    phase = "R8";
    for (int i = 0; i < 2000; i++) begin
      drive(($urandom_range(0, 9) != 0), 1, 3, 2);
      if (!run) begin @(negedge clk); chk("R8", pwm, 0); end
    end

    // R9: ticks while stopped, then restart from count 0
    phase = "R9";
    drive(0, 1, 2, 1);
    for (int i = 0; i < 10; i++) drive(0, 1, 2, 1);
    drive(1, 0, 2, 1);
    @(negedge clk);
    chk("R9", pwm, 1);
    for (int i = 0; i < 3000; i++)
      drive(($urandom_range(0, 15) != 0), $urandom_range(0, 1),
            $urandom_range(0, 255), $urandom_range(0, 255));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule